// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous on-chip requester to an external asynchronous static RAM of 262,144 words of 16 bits. The requester hands over one word at a time on a valid/ready handshake. Each request carries a write flag, an 18-bit word address, 16 bits of write data and two byte-enable bits. The controller then produces the memory-side signals: the address bus, active-low chip enable, output enable and write enable, and active-low upper and lower byte strobes. The data bus is split into an output word, a driver enable and an input word, so the pad ring can build the tri-state pins from them.

Every analog timing window of the memory is turned into a whole number of system-clock cycles. Two parameters set this: a speed-grade selector and the clock period in nanoseconds. Each window is rounded up by ceiling division. A fixed sequence spaces the strobes. First the address is set up with all strobes high. Then comes either a timed read with a capture cycle, or a timed write pulse followed by a data-hold cycle. Last comes a turnaround in which nothing drives the bus. A read returns its data on a one-cycle response strobe, and lanes whose byte enable was clear come back as zero.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the chip enable, output enable, write enable and both byte strobes are high. The data driver enable is 0, reqReady is 1 and rspValid is 0.
- R2: The address of an accepted request appears on sramAddr in the cycle after acceptance, with every strobe still high in that cycle. It stays unchanged until the request completes. The address changes only in a cycle in which chip enable and write enable are high and were high in the cycle before.
- R3: A read holds chip enable and output enable low for READ_CYC+1 cycles, with write enable high. The data bus is sampled at the end of the last of these cycles. rspValid is then high for exactly one cycle, carrying the sampled data on rspData.
- R4: Byte-enable bit 1 drives the upper byte strobe (sramUbN, data bits 15:8) and bit 0 drives the lower byte strobe (sramLbN, bits 7:0). Each strobe goes low during an access only if its enable bit is set. A write leaves the unselected lanes of the memory unchanged, and a read returns 0 on the unselected lanes.
- R5: A write holds write enable and chip enable low together for exactly WP_CYC consecutive cycles, and output enable stays high for the whole write.
- R6: The data driver is enabled from the first cycle of the write pulse until one cycle after write enable has risen, WP_CYC+1 cycles in all. The write data stays stable on sramDqOut throughout, so it is held past the edge that ends the write.
- R7: reqReady is low from the cycle after acceptance up to the end of a turnaround of REL_CYC cycles with all strobes high and the driver off. A read keeps reqReady low for 2+READ_CYC+REL_CYC cycles and a write for 2+WP_CYC+REL_CYC cycles.
- R8: The data driver is never enabled while output enable is low. It is also never enabled within REL_CYC cycles after output enable rises, so a read is never followed directly by a drive of the bus.
- R9: The cycle counts use ceiling division of nanosecond windows by the clock period. The fast grade uses 70 ns access, 35 ns output-enable access, 35 ns release and 55 ns write pulse. The slow grade uses 100, 50, 40 and 70 ns. READ_CYC is the larger of the access and output-enable counts. With the fast grade at 20 ns this gives READ_CYC=4, WP_CYC=3 and REL_CYC=2, so rspValid is seen 3+READ_CYC cycles after acceptance.
- R10: A write never produces rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| rspValid | output | 1 | One-cycle read response strobe |
| rspData | output | 16 | Read data, unselected lanes zero |
| sramAddr | output | 18 | Memory address bus |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramUbN | output | 1 | Upper byte strobe, active low |
| sramLbN | output | 1 | Lower byte strobe, active low |
| sramDqOut | output | 16 | Data toward the memory pins |
| sramDqOe | output | 1 | Enable for the pin data drivers |
| sramDqIn | input | 16 | Data read from the memory pins |

## Verification
A state decoder that is wrong shows up within the same transaction. It appears as a strobe edge one cycle early or late, as a write pulse of the wrong length, or as the driver overlapping output enable. The checker catches this in the cycle it happens, and the bench catches it in the per-transaction cycle counts. A counter reload that is wrong shows as reqReady returning at the wrong time, or as rspValid appearing at the wrong latency. A lane or capture register that is wrong shows as corrupted words in the bench's memory image. These are reported when the word is read back, which can be many transactions later in the random phase.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RD_WAIT, ST_RD_CAPT, ST_WR_PULSE, ST_WR_HOLD, ST_TURN
  } ctrlState_t;

  // Strobes from control to datapath; pin strobes are active low.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic laneOn;
    logic dqDrive;
    logic capture;
  } busStrobes_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int readCycles(input int fastGrade, input int periodNs);
    int acc;
    int oe;
    acc = ceilDiv(fastGrade != 0 ? 70 : 100, periodNs);
    oe  = ceilDiv(fastGrade != 0 ? 35 : 50, periodNs);
    return (acc > oe) ? acc : oe;
  endfunction

  function automatic int pulseCycles(input int fastGrade, input int periodNs);
    return ceilDiv(fastGrade != 0 ? 55 : 70, periodNs);
  endfunction

  // Longest time the memory may keep driving after deselect or strobe removal.
  function automatic int releaseCycles(input int fastGrade, input int periodNs);
    return ceilDiv(fastGrade != 0 ? 35 : 40, periodNs);
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int READ_CYC = 4,
  parameter int WP_CYC   = 3,
  parameter int REL_CYC  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        accept,
  output busStrobes_t strb
);

  localparam int MAX_A = (READ_CYC > WP_CYC) ? READ_CYC : WP_CYC;
  localparam int MAX_C = (MAX_A > REL_CYC) ? MAX_A : REL_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctrlState_t stateQ, stateNext;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic writeQ;

  function automatic busStrobes_t decode(input ctrlState_t st);
    busStrobes_t s;
    s = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, laneOn: 1'b0, dqDrive: 1'b0, capture: 1'b0};
    case (st)
      ST_RD_WAIT: begin s.ceN = 1'b0; s.oeN = 1'b0; s.laneOn = 1'b1; end
      ST_RD_CAPT: begin s.ceN = 1'b0; s.oeN = 1'b0; s.laneOn = 1'b1; s.capture = 1'b1; end
      ST_WR_PULSE: begin s.ceN = 1'b0; s.weN = 1'b0; s.laneOn = 1'b1; s.dqDrive = 1'b1; end
      ST_WR_HOLD: s.dqDrive = 1'b1;
      default: ;
    endcase
    return s;
  endfunction

  assign reqReady = (stateQ == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext = stateQ;
    cntNext   = cntQ;
    case (stateQ)
      ST_IDLE:  if (reqValid) stateNext = ST_SETUP;
      ST_SETUP: begin
        if (writeQ) begin
          stateNext = ST_WR_PULSE;
          cntNext   = CNT_W'(WP_CYC - 1);
        end else begin
          stateNext = ST_RD_WAIT;
          cntNext   = CNT_W'(READ_CYC - 1);
        end
      end
      ST_RD_WAIT: begin
        if (cntQ == '0) stateNext = ST_RD_CAPT;
        else cntNext = cntQ - CNT_W'(1);
      end
      ST_RD_CAPT: begin
        stateNext = ST_TURN;
        cntNext   = CNT_W'(REL_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (cntQ == '0) stateNext = ST_WR_HOLD;
        else cntNext = cntQ - CNT_W'(1);
      end
      ST_WR_HOLD: begin
        stateNext = ST_TURN;
        cntNext   = CNT_W'(REL_CYC - 1);
      end
      ST_TURN: begin
        if (cntQ == '0) stateNext = ST_IDLE;
        else cntNext = cntQ - CNT_W'(1);
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      writeQ <= 1'b0;
      strb   <= decode(ST_IDLE);
    end else begin
      stateQ <= stateNext;
      cntQ   <= cntNext;
      strb   <= decode(stateNext);
      if (accept) writeQ <= reqWrite;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accept,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  input  busStrobes_t         strb,
  input  logic [DATA_W-1:0]   sramDqIn,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic                sramCeN,
  output logic                sramOeN,
  output logic                sramWeN,
  output logic [DATA_W/8-1:0] sramLaneN,
  output logic [DATA_W-1:0]   sramDqOut,
  output logic                sramDqOe,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ, laneMask;
  logic [LANES-1:0]  beQ;
  logic              rspQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneMask[g*8 +: 8] = {8{beQ[g]}};
    assign sramLaneN[g]       = ~(beQ[g] & strb.laneOn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      if (accept) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      if (strb.capture) rdataQ <= sramDqIn & laneMask;
      rspQ <= strb.capture;
    end
  end

  assign sramAddr  = addrQ;
  assign sramCeN   = strb.ceN;
  assign sramOeN   = strb.oeN;
  assign sramWeN   = strb.weN;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strb.dqDrive;
  assign rspValid  = rspQ;
  assign rspData   = rdataQ;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int FAST_GRADE    = 1,
  parameter int CLK_PERIOD_NS = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [17:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqBe,
  output logic        rspValid,
  output logic [15:0] rspData,
  output logic [17:0] sramAddr,
  output logic        sramCeN,
  output logic        sramOeN,
  output logic        sramWeN,
  output logic        sramUbN,
  output logic        sramLbN,
  output logic [15:0] sramDqOut,
  output logic        sramDqOe,
  input  logic [15:0] sramDqIn
);

  localparam int READ_CYC = readCycles(FAST_GRADE, CLK_PERIOD_NS);
  localparam int WP_CYC   = pulseCycles(FAST_GRADE, CLK_PERIOD_NS);
  localparam int REL_CYC  = releaseCycles(FAST_GRADE, CLK_PERIOD_NS);

  busStrobes_t strb;
  logic        accept;
  logic [1:0]  laneN;

  sram_ctrl_fsm #(.READ_CYC(READ_CYC), .WP_CYC(WP_CYC), .REL_CYC(REL_CYC)) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .accept(accept), .strb(strb)
  );

  sram_ctrl_datapath #(.ADDR_W(18), .DATA_W(16)) uData (
    .clk(clk), .rstN(rstN), .accept(accept), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .strb(strb), .sramDqIn(sramDqIn),
    .sramAddr(sramAddr), .sramCeN(sramCeN), .sramOeN(sramOeN),
    .sramWeN(sramWeN), .sramLaneN(laneN), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .rspValid(rspValid), .rspData(rspData)
  );

  assign sramUbN = laneN[1];
  assign sramLbN = laneN[0];

endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
module sram_ctrl_checker #(
  parameter int WP_CYC  = 3,
  parameter int REL_CYC = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        rspValid,
  input logic [17:0] sramAddr,
  input logic        sramCeN,
  input logic        sramOeN,
  input logic        sramWeN,
  input logic        sramDqOe,
  input logic [15:0] sramDqOut
);

  logic [7:0] relCnt;
  logic [7:0] wpCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relCnt <= 8'(REL_CYC);
      wpCnt  <= '0;
    end else begin
      if (!sramOeN) relCnt <= '0;
      else if (relCnt != 8'hFF) relCnt <= relCnt + 8'd1;
      if (!sramWeN) wpCnt <= wpCnt + 8'd1;
      else wpCnt <= '0;
    end
  end

  assert_addr_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sramAddr) |-> (sramWeN && $past(sramWeN) && sramCeN && $past(sramCeN)));

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_we_with_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCeN && sramOeN));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (wpCnt == 8'(WP_CYC)));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (sramDqOe && $stable(sramDqOut)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCeN && sramWeN && sramOeN && !sramDqOe));

  assert_bus_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> (sramOeN && relCnt >= 8'(REL_CYC)));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(.WP_CYC(WP_CYC), .REL_CYC(REL_CYC)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .sramAddr(sramAddr), .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
  .sramDqOe(sramDqOe), .sramDqOut(sramDqOut)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  function automatic int ceilNs(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  localparam int PER   = 20;
  localparam int ACC_E = (ceilNs(70, PER) > ceilNs(35, PER)) ? ceilNs(70, PER) : ceilNs(35, PER);
  localparam int WP_E  = ceilNs(55, PER);
  localparam int REL_E = ceilNs(35, PER);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic reqReady, rspValid;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic [15:0] rspData;
  logic [17:0] sramAddr;
  logic sramCeN, sramOeN, sramWeN, sramUbN, sramLbN, sramDqOe;
  logic [15:0] sramDqOut, sramDqIn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] modelMem [256];
  logic [15:0] expMem [256];

  always #10 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramUbN(sramUbN), .sramLbN(sramLbN), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // External memory model: stores lanes while selected with write enable low.
  always @(posedge clk) begin
    if (!sramCeN && !sramWeN && sramDqOe) begin
      if (!sramLbN) modelMem[sramAddr[7:0]][7:0]  <= sramDqOut[7:0];
      if (!sramUbN) modelMem[sramAddr[7:0]][15:8] <= sramDqOut[15:8];
    end
  end

  always_comb begin
    if (!sramCeN && !sramOeN)
      sramDqIn = {(!sramUbN ? modelMem[sramAddr[7:0]][15:8] : 8'hA5),
                  (!sramLbN ? modelMem[sramAddr[7:0]][7:0]  : 8'h5A)};
    else
      sramDqIn = 16'hC3C3;
  end

  function automatic logic [15:0] expRead(input logic [17:0] a, input logic [1:0] be);
    return expMem[a[7:0]] & {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] be);
    int n, busy, rspAt, rspCnt, ceLow, weLow, drvCnt, addrBad, drvBad, conflict;
    logic [15:0] got;
    bit setupQuiet;
    n = 0; busy = 0; rspAt = 0; rspCnt = 0; ceLow = 0; weLow = 0;
    drvCnt = 0; addrBad = 0; drvBad = 0; conflict = 0; got = '0; setupQuiet = 1'b0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        reqValid = 1'b0;
        setupQuiet = sramCeN && sramOeN && sramWeN && sramUbN && sramLbN && !sramDqOe;
      end
      if (reqReady) break;
      busy++;
      if (sramAddr != a) addrBad++;
      if (!sramCeN) ceLow++;
      if (!sramWeN) weLow++;
      if (sramDqOe) begin
        drvCnt++;
        if (sramDqOut != d) drvBad++;
      end
      if (!sramOeN && sramDqOe) conflict++;
      if (!sramCeN && (sramUbN != !be[1] || sramLbN != !be[0])) conflict++;
      if (rspValid) begin
        rspCnt++; rspAt = n; got = rspData;
      end
    end
    check(setupQuiet, "R2 setup cycle strobes high", int'(setupQuiet), 1);
    check(addrBad == 0, "R2 address held", addrBad, 0);
    check(conflict == 0, "R4/R8 lane strobes and driver overlap", conflict, 0);
    if (wr) begin
      check(busy == 2 + WP_E + REL_E, "R7 write busy cycles", busy, 2 + WP_E + REL_E);
      check(weLow == WP_E && ceLow == WP_E, "R5 write pulse cycles", weLow, WP_E);
      check(drvCnt == WP_E + 1 && drvBad == 0, "R6 drive window", drvCnt, WP_E + 1);
      check(rspCnt == 0, "R10 no response on write", rspCnt, 0);
      if (be[0]) expMem[a[7:0]][7:0]  = d[7:0];
      if (be[1]) expMem[a[7:0]][15:8] = d[15:8];
    end else begin
      check(busy == 2 + ACC_E + REL_E, "R7 read busy cycles", busy, 2 + ACC_E + REL_E);
      check(ceLow == ACC_E + 1, "R3 read strobe cycles", ceLow, ACC_E + 1);
      check(rspCnt == 1, "R3 single response", rspCnt, 1);
      check(rspAt == 3 + ACC_E, "R9 response latency", rspAt, 3 + ACC_E);
      check(got == expRead(a, be), "R4 read data lanes", int'(got), int'(expRead(a, be)));
      check(drvCnt == 0, "R8 no drive on read", drvCnt, 0);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      modelMem[i] = 16'(i * 16'h9E37 + 16'h1357);
      expMem[i]   = 16'(i * 16'h9E37 + 16'h1357);
    end
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && sramUbN && sramLbN && !sramDqOe
          && reqReady && !rspValid, "R1 state in reset", 0, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && sramUbN && sramLbN && !sramDqOe
          && reqReady && !rspValid, "R1 state after reset", 0, 1);

    xfer(1'b1, 18'h00003, 16'h1234, 2'b11);
    xfer(1'b0, 18'h00003, 16'h0000, 2'b11);
    xfer(1'b1, 18'h00003, 16'hABCD, 2'b01);   // R4 lower lane only
    xfer(1'b0, 18'h00003, 16'h0000, 2'b11);
    xfer(1'b0, 18'h00003, 16'h0000, 2'b10);   // R4 upper lane, lower returns zero
    xfer(1'b1, 18'h00003, 16'hFFFF, 2'b00);   // R4 no lane written
    xfer(1'b0, 18'h00003, 16'h0000, 2'b11);
    xfer(1'b1, 18'h3FFFF, 16'h5AA5, 2'b10);   // R2 top address
    xfer(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
    xfer(1'b0, 18'h3FFFF, 16'h0000, 2'b00);

    for (int t = 0; t < 400; t++) begin
      xfer(1'($urandom_range(0, 1)), 18'($urandom), 16'($urandom), 2'($urandom_range(0, 3)));
    end
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule